// File: doc/BRIEF.md
# Four-Channel Edge-Selectable Input Capture Unit

This block sits next to a free-running timer and records when external events occur. It has four channels. Each channel watches one trigger input that is already synchronous to the system clock. When a selected transition appears on that input, the channel stores the current timer value in its capture register and raises a sticky event flag. Downstream interrupt logic can then act on the flag. An edge-select byte chooses, for each channel, rising edges, falling edges, both edges or neither.

The timer counts up by one on every clock cycle. It keeps two sticky wrap flags. One marks the full-width wrap from all-ones to zero. The other marks every wrap of the low byte from 0xFF to 0x00. Software clears the event flags and the wrap flags with write-one-to-clear strobes. When a new event and a clear strobe arrive in the same cycle, the event wins.

Top module: `cap_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the following all read zero: the timer count, the edge-select byte, all capture values, all event flags and both wrap flags.
- R2: The timer count rises by exactly one every clock cycle and wraps from 0xFFFF to 0x0000.
- R3: A write strobe loads the edge-select byte at the next clock edge. The new value is visible on `ctrl_q_o` and governs edges seen in the following cycles.
- R4: When bit 2n of the edge-select byte is 1, a rising edge on `trig_i[n]` loads capture register n with the timer count of the cycle in which the input is first high. It also sets flag n. Both are visible one cycle later.
- R5: When bit 2n+1 is 1, a falling edge on `trig_i[n]` captures in the same way. The value taken is the count of the cycle in which the input is first low.
- R6: A channel whose two select bits are both 1 captures on either edge. A channel whose select bits do not enable a given edge leaves its capture value and flag unchanged when that edge occurs.
- R7: An event flag stays set until a 1 on its bit of `flag_clr_i`. A capture in the same cycle as the clear leaves the flag set.
- R8: The full-wrap flag becomes 1 in the cycle in which the count reads 0x0000 after 0xFFFF. It stays set until `ovf_clr_i[0]` is pulsed.
- R9: The byte-wrap flag becomes 1 in the cycle in which the low byte reads 0x00 after 0xFF. This includes the full wrap. It is cleared by `ovf_clr_i[1]`. A wrap in the same cycle as that clear leaves it set.
- R10: An edge on one channel never changes the capture value or the flag of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 4 | Synchronised trigger inputs, bit n for channel n |
| ctrl_we_i | input | 1 | Write strobe for the edge-select byte |
| ctrl_wdata_i | input | 8 | New edge-select byte: bit 2n rising, bit 2n+1 falling for channel n |
| ctrl_q_o | output | 8 | Current edge-select byte |
| flag_clr_i | input | 4 | Write-one-to-clear strobes for the event flags |
| ovf_clr_i | input | 2 | Write-one-to-clear strobes: bit 0 full wrap, bit 1 byte wrap |
| tmr_count_o | output | 16 | Current timer count |
| cap_val_o | output | 64 | Capture registers, channel n in bits 16n+15..16n |
| cap_flag_o | output | 4 | Sticky event flags |
| ovf_full_o | output | 1 | Sticky 16-bit wrap flag |
| ovf_byte_o | output | 1 | Sticky low-byte wrap flag |

## Verification
Every result is registered once, so it is due at the first clock edge after its cause. Examples are a capture value and flag after an input transition, the edge-select byte after its write strobe, a wrap flag after the count reaches all-ones, and a cleared flag after its strobe. The bench drives inputs and samples outputs on the falling clock edge. It records the visible count at the moment it changes a trigger. It then compares the capture register exactly one falling edge later, so the expected value is the count that was current while the new level was first present. Wrap flags are checked at the falling edge where the count first reads 0x0000 or 0x0100, and also the edge before, to confirm they were not set early.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int unsigned NUM_CH_DEF = 4;
    localparam int unsigned TMR_W_DEF  = 16;
    localparam int unsigned BYTE_W_DEF = 8;

    // Per-channel select code: {falling enable, rising enable}
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic logic edge_hit(input edge_mode_e mode, input edge_t e);
        logic hit;
        case (mode)
            EDGE_RISE: hit = e.rise;
            EDGE_FALL: hit = e.fall;
            EDGE_BOTH: hit = e.rise | e.fall;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/cap_timer.sv
module cap_timer #(
    parameter int unsigned TMR_W  = cap_pkg::TMR_W_DEF,
    parameter int unsigned BYTE_W = cap_pkg::BYTE_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_full_i,
    input  logic             clr_byte_i,
    output logic [TMR_W-1:0] count_o,
    output logic             ovf_full_o,
    output logic             ovf_byte_o
);

    logic [TMR_W-1:0] cnt_q;
    logic             full_q;
    logic             byte_q;
    logic             wrap_full;
    logic             wrap_byte;

    assign wrap_full = &cnt_q;
    assign wrap_byte = &cnt_q[BYTE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
            byte_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_q + TMR_W'(1);
            full_q <= wrap_full | (full_q & ~clr_full_i);
            byte_q <= wrap_byte | (byte_q & ~clr_byte_i);
        end
    end

    assign count_o    = cnt_q;
    assign ovf_full_o = full_q;
    assign ovf_byte_o = byte_q;

    // R2: count steps by one each cycle
    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cnt_q == $past(cnt_q) + TMR_W'(1));

    // R8: count at zero after all-ones means full flag is up
    assert_full_set_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && $past(cnt_q) == {TMR_W{1'b1}}) |-> full_q);

    // R8: flag holds without a clear strobe
    assert_full_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (full_q && !clr_full_i) |=> full_q);

    // R9: low byte at zero after 0xFF means byte flag is up
    assert_byte_set_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt_q[BYTE_W-1:0] == '0 && $past(cnt_q[BYTE_W-1:0]) == {BYTE_W{1'b1}}) |-> byte_q);

    // R9: a full wrap is also a byte wrap
    assert_full_has_byte_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(full_q) |-> byte_q);

endmodule

// File: rtl/cap_edge_det.sv
module cap_edge_det (
    input  logic           clk,
    input  logic           rst,
    input  logic           sig_i,
    output cap_pkg::edge_t edge_o
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sig_i;
    end

    assign edge_o.rise = sig_i & ~prev_q;
    assign edge_o.fall = ~sig_i & prev_q;

    // R4 / R5: a detected edge is followed by a level that held
    assert_rise_level_R4: assert property (@(posedge clk) disable iff (rst)
        edge_o.rise |=> prev_q);
    assert_fall_level_R5: assert property (@(posedge clk) disable iff (rst)
        edge_o.fall |=> !prev_q);

endmodule

// File: rtl/cap_channel.sv
module cap_channel #(
    parameter int unsigned TMR_W = cap_pkg::TMR_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  cap_pkg::edge_t      edge_i,
    input  cap_pkg::edge_mode_e mode_i,
    input  logic [TMR_W-1:0]    count_i,
    input  logic                clr_i,
    output logic [TMR_W-1:0]    cap_o,
    output logic                flag_o
);

    logic [TMR_W-1:0] cap_q;
    logic             flag_q;
    logic             hit;

    assign hit = cap_pkg::edge_hit(mode_i, edge_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (hit) cap_q <= count_i;
            flag_q <= hit | (flag_q & ~clr_i);
        end
    end

    assign cap_o  = cap_q;
    assign flag_o = flag_q;

    // R4: capture takes the count of the detecting cycle
    assert_capture_value_R4: assert property (@(posedge clk) disable iff (rst)
        hit |=> cap_q == $past(count_i));

    // R6: no hit, no change
    assert_capture_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(cap_q));

    // R7: event wins over a same-cycle clear
    assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag_q);

    // R7: clear without event drops the flag
    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (!hit && clr_i) |=> !flag_q);

endmodule

// File: rtl/cap_unit.sv
module cap_unit #(
    parameter int unsigned NUM_CH = cap_pkg::NUM_CH_DEF,
    parameter int unsigned TMR_W  = cap_pkg::TMR_W_DEF,
    parameter int unsigned BYTE_W = cap_pkg::BYTE_W_DEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_CH-1:0]         trig_i,
    input  logic                      ctrl_we_i,
    input  logic [2*NUM_CH-1:0]       ctrl_wdata_i,
    output logic [2*NUM_CH-1:0]       ctrl_q_o,
    input  logic [NUM_CH-1:0]         flag_clr_i,
    input  logic [1:0]                ovf_clr_i,
    output logic [TMR_W-1:0]          tmr_count_o,
    output logic [NUM_CH*TMR_W-1:0]   cap_val_o,
    output logic [NUM_CH-1:0]         cap_flag_o,
    output logic                      ovf_full_o,
    output logic                      ovf_byte_o
);

    localparam int unsigned CTRL_W = 2 * NUM_CH;

    logic [CTRL_W-1:0] ctrl_q;
    logic [TMR_W-1:0]  count;

    always_ff @(posedge clk) begin
        if (rst)            ctrl_q <= '0;
        else if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
    end

    assign ctrl_q_o    = ctrl_q;
    assign tmr_count_o = count;

    cap_timer #(
        .TMR_W  (TMR_W),
        .BYTE_W (BYTE_W)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .clr_full_i (ovf_clr_i[0]),
        .clr_byte_i (ovf_clr_i[1]),
        .count_o    (count),
        .ovf_full_o (ovf_full_o),
        .ovf_byte_o (ovf_byte_o)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        cap_pkg::edge_t      edges;
        cap_pkg::edge_mode_e mode;
        logic [TMR_W-1:0]    cap_w;

        assign mode = cap_pkg::edge_mode_e'(ctrl_q[2*g +: 2]);

        cap_edge_det u_det (
            .clk    (clk),
            .rst    (rst),
            .sig_i  (trig_i[g]),
            .edge_o (edges)
        );

        cap_channel #(
            .TMR_W (TMR_W)
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .edge_i  (edges),
            .mode_i  (mode),
            .count_i (count),
            .clr_i   (flag_clr_i[g]),
            .cap_o   (cap_w),
            .flag_o  (cap_flag_o[g])
        );

        assign cap_val_o[g*TMR_W +: TMR_W] = cap_w;
    end

    // R3: write strobe loads the select byte at the next edge
    assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl_we_i |=> ctrl_q == $past(ctrl_wdata_i));

    // R3: no strobe, no change
    assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !ctrl_we_i |=> $stable(ctrl_q));

endmodule

// File: tb/tb_cap_unit.sv
module tb_cap_unit;

    localparam int NCH = 4;
    localparam int TW  = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NCH-1:0]  trig = '0;
    logic            ctrl_we = 1'b0;
    logic [7:0]      ctrl_wdata = '0;
    logic [7:0]      ctrl_q;
    logic [NCH-1:0]  flag_clr = '0;
    logic [1:0]      ovf_clr = '0;
    logic [TW-1:0]   count;
    logic [NCH*TW-1:0] cap_val;
    logic [NCH-1:0]  cap_flag;
    logic            ovf_full;
    logic            ovf_byte;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    cap_unit dut (
        .clk          (clk),
        .rst          (rst),
        .trig_i       (trig),
        .ctrl_we_i    (ctrl_we),
        .ctrl_wdata_i (ctrl_wdata),
        .ctrl_q_o     (ctrl_q),
        .flag_clr_i   (flag_clr),
        .ovf_clr_i    (ovf_clr),
        .tmr_count_o  (count),
        .cap_val_o    (cap_val),
        .cap_flag_o   (cap_flag),
        .ovf_full_o   (ovf_full),
        .ovf_byte_o   (ovf_byte)
    );

    // {select byte[11:4], channel[3:2], rising(1)/falling(0)[1], capture expected[0]}
    localparam logic [11:0] VEC [14] = '{
        {8'h01, 2'd0, 1'b1, 1'b1},
        {8'h01, 2'd0, 1'b0, 1'b0},
        {8'h02, 2'd0, 1'b0, 1'b1},
        {8'h02, 2'd0, 1'b1, 1'b0},
        {8'h0C, 2'd1, 1'b1, 1'b1},
        {8'h0C, 2'd1, 1'b0, 1'b1},
        {8'h10, 2'd2, 1'b1, 1'b1},
        {8'h20, 2'd2, 1'b0, 1'b1},
        {8'hC0, 2'd3, 1'b0, 1'b1},
        {8'hC0, 2'd3, 1'b1, 1'b1},
        {8'h00, 2'd3, 1'b1, 1'b0},
        {8'h00, 2'd3, 1'b0, 1'b0},
        {8'h01, 2'd1, 1'b1, 1'b0},
        {8'hFF, 2'd2, 1'b0, 1'b1}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [TW-1:0]     snap_cnt;
        logic [NCH*TW-1:0] snap_cap;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 count", count, 0);
        check("R1 ctrl", ctrl_q, 0);
        check("R1 caps", cap_val, 0);
        check("R1 flags", {cap_flag, ovf_full, ovf_byte}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 count after release", count, 1);
        check("R1 flags after release", {cap_flag, ovf_full, ovf_byte}, 0);

        // R2: step by one
        snap_cnt = count;
        @(negedge clk);
        check("R2 step", count, snap_cnt + 16'd1);

        // R3: select byte write
        wr_ctrl(8'hA5);
        check("R3 ctrl readback", ctrl_q, 8'hA5);

        // Vector table: R4 rising, R5 falling, R6 disabled/both, R10 isolation
        for (int i = 0; i < 14; i++) begin
            logic [7:0] vc;
            int         ch;
            logic       rise_dir;
            logic       expc;
            logic [TW-1:0] exp_cap;
            vc       = VEC[i][11:4];
            ch       = int'(VEC[i][3:2]);
            rise_dir = VEC[i][1];
            expc     = VEC[i][0];
            wr_ctrl(8'h00);
            trig[ch] = ~rise_dir;
            @(negedge clk);
            flag_clr = '1;
            @(negedge clk);
            flag_clr = '0;
            wr_ctrl(vc);
            snap_cap = cap_val;
            snap_cnt = count;
            trig[ch] = rise_dir;
            @(negedge clk);
            exp_cap = expc ? snap_cnt : snap_cap[ch*TW +: TW];
            if (rise_dir) begin
                check(expc ? "R4 rising capture value" : "R6 rising ignored value",
                      cap_val[ch*TW +: TW], exp_cap);
                check(expc ? "R4 rising flag" : "R6 rising ignored flag",
                      cap_flag, expc ? (4'b1 << ch) : 4'b0);
            end else begin
                check(expc ? "R5 falling capture value" : "R6 falling ignored value",
                      cap_val[ch*TW +: TW], exp_cap);
                check(expc ? "R5 falling flag" : "R6 falling ignored flag",
                      cap_flag, expc ? (4'b1 << ch) : 4'b0);
            end
            for (int k = 0; k < NCH; k++) begin
                if (k != ch)
                    check("R10 other channel untouched", cap_val[k*TW +: TW], snap_cap[k*TW +: TW]);
            end
        end

        // R7: event wins over clear, flag sticky, clear drops it
        wr_ctrl(8'h00);
        trig[0] = 1'b0;
        @(negedge clk);
        flag_clr = '1;
        @(negedge clk);
        flag_clr = '0;
        wr_ctrl(8'h01);
        trig[0]  = 1'b1;
        flag_clr = 4'b0001;
        @(negedge clk);
        flag_clr = '0;
        check("R7 event wins over clear", cap_flag[0], 1'b1);
        repeat (3) @(negedge clk);
        check("R7 flag sticky", cap_flag[0], 1'b1);
        flag_clr = 4'b0001;
        @(negedge clk);
        flag_clr = '0;
        check("R7 flag cleared", cap_flag[0], 1'b0);

        // R8 / R9: wrap flags
        while (count != 16'hFFFE) @(negedge clk);
        ovf_clr = 2'b11;
        @(negedge clk);
        ovf_clr = 2'b00;
        check("R8 full flag not early", ovf_full, 1'b0);
        check("R9 byte flag not early", ovf_byte, 1'b0);
        @(negedge clk);
        check("R2 wrap to zero", count, 16'h0000);
        check("R8 full flag set on wrap", ovf_full, 1'b1);
        check("R9 byte flag set on full wrap", ovf_byte, 1'b1);
        @(negedge clk);
        check("R8 full flag sticky", ovf_full, 1'b1);
        ovf_clr = 2'b10;
        @(negedge clk);
        ovf_clr = 2'b00;
        check("R9 byte flag cleared", ovf_byte, 1'b0);
        check("R8 full flag kept on byte clear", ovf_full, 1'b1);
        ovf_clr = 2'b01;
        @(negedge clk);
        ovf_clr = 2'b00;
        check("R8 full flag cleared", ovf_full, 1'b0);
        while (count != 16'h00FF) @(negedge clk);
        check("R9 byte flag low before wrap", ovf_byte, 1'b0);
        ovf_clr = 2'b10;
        @(negedge clk);
        ovf_clr = 2'b00;
        check("R9 byte wrap count", count, 16'h0100);
        check("R9 byte wrap wins over clear", ovf_byte, 1'b1);
        check("R8 full flag not set by byte wrap", ovf_full, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule